// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drains a circular list of transmit descriptors that software places in host memory. Each descriptor is two 32-bit words: a control/status word and a pointer to a buffer fragment. Once started, the engine fetches descriptors one at a time over a simple word-wide memory port with a valid/ready handshake. It copies each fragment byte by byte into a local frame store. It returns every descriptor to software by writing its control word back with the ownership bit cleared.

A frame may span several descriptors. The descriptor that opens a frame supplies two values: where a 16-bit ones-complement checksum begins, and where its result is to be placed. The checksum runs across all fragments of the frame. When the closing descriptor arrives, the result is stored most significant byte first, and the frame is streamed out as bytes together with its total length, provided transmission is enabled. The block raises a one-cycle event for each descriptor it finishes, and a second event when it reaches a descriptor it does not own. Writing any nonzero value to the pending register starts a pass.

Top module: `txr_engine`

## Requirements
- R1: A write of a nonzero value to the pending register while the engine is idle starts a pass, and the first memory request follows in the next cycle. A write of zero starts nothing and produces no memory request.
- R2: The ring register holds the ring base in bits 31:8 (256-byte aligned) and the current descriptor index in bits 7:0. Descriptor i has its control word at base + 8*i and its buffer pointer at base + 8*i + 4.
- R3: If a fetched control word has bit 31 (own) clear, the engine raises `evt_ring_idle` for one cycle, returns to idle and writes nothing to memory.
- R4: After its fragment is handled, each owned descriptor's control word is written back to the same address with bit 31 cleared and all other bits unchanged. The index then advances by one, wrapping to 0 when it reaches (ring_size + 1) * 16.
- R5: Control word fields: bit 30 opens a frame, bit 29 closes it, bit 28 enables the checksum, bits 27:20 give the stuff offset, bits 19:14 give the checksum start offset, and bits 12:0 give the fragment length. Fragment bytes are read from little-endian memory words starting at any byte address. They are appended in order, and the frame is emitted once its closing descriptor has been handled, with `frm_len` equal to the byte count.
- R6: The frame store holds FBUF_BYTES (2048) bytes. A fragment that would overflow it is cut to the remaining space.
- R7: The checksum covers the frame bytes at and after the start offset. Bytes are paired relative to that offset, with the first byte of each pair as the high byte, and an odd trailing byte is padded with zero. Bytes are summed only from descriptors that have bit 28 set. If the closing descriptor has bit 28 set, the inverted folded sum is written with its high byte at the stuff offset and its low byte at the next position.
- R8: A finished frame appears on the byte stream only while `tx_enable` is high. Descriptors are written back either way.
- R9: Every descriptor write-back raises `evt_desc_done` in the cycle its write is accepted and clears the pending register, unless a pending write arrives in the same cycle.
- R10: A memory request that is not accepted keeps its address, direction and data until `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_wr | input | 1 | Write strobe for the pending register |
| pend_wdata | input | 32 | Value written to the pending register |
| ring_wr | input | 1 | Write strobe for the ring register (taken only while idle) |
| ring_wdata | input | 32 | Ring base and index value |
| ring_size | input | 8 | Ring size code; descriptor count is (code+1)*16 |
| tx_enable | input | 1 | Allows finished frames onto the byte stream |
| pend_reg | output | 32 | Current pending register |
| ring_reg | output | 32 | Current ring register (base and index) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| frm_valid | output | 1 | Frame byte valid |
| frm_data | output | 8 | Frame byte |
| frm_last | output | 1 | Final byte of the frame |
| frm_len | output | 12 | Frame length in bytes, held during the frame |
| evt_desc_done | output | 1 | Pulse per descriptor returned |
| evt_ring_idle | output | 1 | Pulse when a non-owned descriptor is reached |

## Verification
Only the first result has a fixed latency: the first memory request appears exactly one cycle after a nonzero pending write, and the bench samples it on the next falling edge. The other results arrive after a variable number of cycles, because the bench's memory withholds ready on alternate cycles, so copying, stuffing and streaming have no fixed length. Event pulses are counted on every falling edge, frame bytes are collected whenever `frm_valid` is high, and each scenario waits for the idle event before comparing the stored frame, the written-back descriptors and the ring index with values computed in the bench.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RD_ST, S_RD_BP, S_RD_WD, S_WR_BY,
    S_STUFF_HI, S_STUFF_LO, S_SEND, S_WBACK
  } txr_state_e;

  localparam int B_OWN = 31;
  localparam int B_SOP = 30;
  localparam int B_EOP = 29;
  localparam int B_CKS = 28;
  localparam int STUFF_LSB = 20;
  localparam int START_LSB = 14;
  localparam int FLEN_W    = 13;
endpackage

// File: rtl/txr_fbuf.sv
module txr_fbuf #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/txr_csum.sv
module txr_csum (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        add,
  input  logic        hi,
  input  logic [7:0]  din,
  output logic [15:0] result
);
  logic [31:0] sum_q, sum_d;
  logic [16:0] fold1;
  logic [15:0] fold2;

  always_comb begin
    sum_d = sum_q;
    if (clr)      sum_d = '0;
    else if (add) sum_d = sum_q + (hi ? {16'h0, din, 8'h00} : {24'h0, din});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign fold1  = {1'b0, sum_q[15:0]} + {1'b0, sum_q[31:16]};
  assign fold2  = fold1[15:0] + {15'h0, fold1[16]};
  assign result = ~fold2;
endmodule

// File: rtl/txr_engine.sv
module txr_engine #(
  parameter int FBUF_BYTES = 2048,
  parameter int IDX_W      = 8,
  localparam int FA_W  = $clog2(FBUF_BYTES),
  localparam int POS_W = FA_W + 1,
  localparam int CNT_W = IDX_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_wr,
  input  logic [31:0]      pend_wdata,
  input  logic             ring_wr,
  input  logic [31:0]      ring_wdata,
  input  logic [IDX_W-1:0] ring_size,
  input  logic             tx_enable,
  output logic [31:0]      pend_reg,
  output logic [31:0]      ring_reg,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ready,
  input  logic [31:0]      mem_rdata,
  output logic             frm_valid,
  output logic [7:0]       frm_data,
  output logic             frm_last,
  output logic [POS_W-1:0] frm_len,
  output logic             evt_desc_done,
  output logic             evt_ring_idle
);
  import txr_pkg::*;

  localparam logic [POS_W-1:0] FULL = POS_W'(FBUF_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  txr_state_e state_q, state_d;
  logic [31:0] ring_q, ring_d, pend_q, pend_d, st_q, st_d, bp_q, bp_d, word_q, word_d;
  logic [FLEN_W-1:0] k_q, k_d, len_q, len_d;
  logic [POS_W-1:0]  pos_q, pos_d, snd_q, snd_d;
  logic [5:0] start_q, start_d;
  logic [7:0] stuff_q, stuff_d;

  // derived values
  logic [31:0]       desc_addr, byte_addr;
  logic [IDX_W:0]    size_p1;
  logic [CNT_W-1:0]  ring_cnt, idx_inc;
  logic [POS_W-1:0]  pos_eff, room, pos_inc;
  logic [FLEN_W-1:0] frag_len, room_l, take;
  logic [7:0]        cur_byte;
  logic [1:0]        lane;

  // frame store and checksum
  logic            fb_we;
  logic [FA_W-1:0] fb_waddr;
  logic [7:0]      fb_wdata;
  logic            cs_clr, cs_add, cs_hi;
  logic [15:0]     cs_res;

  assign desc_addr = {ring_q[31:8], 8'h00} + {{(29-IDX_W){1'b0}}, ring_q[IDX_W-1:0], 3'b000};
  assign size_p1   = {1'b0, ring_size} + 1'b1;
  assign ring_cnt  = {size_p1, 4'b0000};
  assign idx_inc   = {{(CNT_W-IDX_W){1'b0}}, ring_q[IDX_W-1:0]} + 1'b1;
  assign byte_addr = bp_q + {{(32-FLEN_W){1'b0}}, k_q};
  assign lane      = byte_addr[1:0];
  assign cur_byte  = word_q[{lane, 3'b000} +: 8];
  assign pos_eff   = st_q[B_SOP] ? '0 : pos_q;
  assign room      = FULL - pos_eff;
  assign room_l    = FLEN_W'(room);
  assign frag_len  = st_q[FLEN_W-1:0];
  assign take      = (frag_len > room_l) ? room_l : frag_len;
  assign pos_inc   = pos_q + 1'b1;

  function automatic txr_state_e after_copy(input logic [31:0] st, input logic [POS_W-1:0] p,
                                            input logic en);
    if (!st[B_EOP])            return S_WBACK;
    else if (st[B_CKS])        return S_STUFF_HI;
    else if (en && (p != '0))  return S_SEND;
    else                       return S_WBACK;
  endfunction

  always_comb begin
    state_d = state_q; ring_d = ring_q; pend_d = pend_q; st_d = st_q; bp_d = bp_q;
    word_d = word_q; k_d = k_q; len_d = len_q; pos_d = pos_q; snd_d = snd_q;
    start_d = start_q; stuff_d = stuff_q;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    fb_we = 1'b0; fb_waddr = pos_q[FA_W-1:0]; fb_wdata = cur_byte;
    cs_clr = 1'b0; cs_add = 1'b0; cs_hi = 1'b0;
    frm_valid = 1'b0; frm_last = 1'b0;
    evt_desc_done = 1'b0; evt_ring_idle = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (ring_wr) ring_d = ring_wdata;
        if (pend_wr && (pend_wdata != '0)) state_d = S_RD_ST;
      end
      S_RD_ST: begin
        mem_req = 1'b1; mem_addr = desc_addr;
        if (mem_ready) begin
          st_d = mem_rdata;
          if (mem_rdata[B_OWN]) state_d = S_RD_BP;
          else begin evt_ring_idle = 1'b1; state_d = S_IDLE; end
        end
      end
      S_RD_BP: begin
        mem_req = 1'b1; mem_addr = desc_addr + 32'd4;
        if (mem_ready) begin
          bp_d = mem_rdata; k_d = '0; len_d = take; pos_d = pos_eff;
          if (st_q[B_SOP]) begin
            cs_clr  = 1'b1;
            start_d = st_q[START_LSB +: 6];
            stuff_d = st_q[STUFF_LSB +: 8];
          end
          state_d = (take == '0) ? after_copy(st_q, pos_eff, tx_enable) : S_RD_WD;
        end
      end
      S_RD_WD: begin
        mem_req = 1'b1; mem_addr = {byte_addr[31:2], 2'b00};
        if (mem_ready) begin word_d = mem_rdata; state_d = S_WR_BY; end
      end
      S_WR_BY: begin
        fb_we  = 1'b1;
        cs_add = st_q[B_CKS] && (pos_q >= POS_W'(start_q));
        cs_hi  = (pos_q[0] == start_q[0]);
        k_d    = k_q + 1'b1;
        pos_d  = pos_inc;
        if (k_d == len_q)    state_d = after_copy(st_q, pos_inc, tx_enable);
        else if (lane == 2'd3) state_d = S_RD_WD;
      end
      S_STUFF_HI: begin
        fb_we = 1'b1; fb_waddr = FA_W'(stuff_q); fb_wdata = cs_res[15:8];
        state_d = S_STUFF_LO;
      end
      S_STUFF_LO: begin
        fb_we = 1'b1; fb_waddr = FA_W'(stuff_q) + 1'b1; fb_wdata = cs_res[7:0];
        snd_d = '0;
        state_d = (tx_enable && (pos_q != '0)) ? S_SEND : S_WBACK;
      end
      S_SEND: begin
        frm_valid = 1'b1;
        frm_last  = (snd_q + 1'b1 == pos_q);
        snd_d     = snd_q + 1'b1;
        if (frm_last) state_d = S_WBACK;
      end
      S_WBACK: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_addr;
        mem_wdata = st_q & ~(32'h1 << B_OWN);
        if (mem_ready) begin
          evt_desc_done = 1'b1;
          pend_d = '0;
          ring_d[IDX_W-1:0] = (idx_inc >= ring_cnt) ? '0 : idx_inc[IDX_W-1:0];
          if (st_q[B_EOP]) pos_d = '0;
          state_d = S_RD_ST;
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (pend_wr) pend_d = pend_wdata;
    if (state_q != S_SEND && state_d == S_SEND) snd_d = '0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= S_IDLE; ring_q <= '0; pend_q <= '0; st_q <= '0; bp_q <= '0;
      word_q <= '0; k_q <= '0; len_q <= '0; pos_q <= '0; snd_q <= '0;
      start_q <= '0; stuff_q <= '0;
    end else begin
      state_q <= state_d; ring_q <= ring_d; pend_q <= pend_d; st_q <= st_d; bp_q <= bp_d;
      word_q <= word_d; k_q <= k_d; len_q <= len_d; pos_q <= pos_d; snd_q <= snd_d;
      start_q <= start_d; stuff_q <= stuff_d;
    end
  end

  txr_fbuf #(.DEPTH(FBUF_BYTES)) u_fbuf (
    .clk(clk), .we(fb_we), .waddr(fb_waddr), .wdata(fb_wdata),
    .raddr(snd_q[FA_W-1:0]), .rdata(frm_data)
  );

  txr_csum u_csum (
    .clk(clk), .rst_n(rst_i_n), .clr(cs_clr), .add(cs_add), .hi(cs_hi),
    .din(cur_byte), .result(cs_res)
  );

  assign pend_reg = pend_q;
  assign ring_reg = ring_q;
  assign frm_len  = pos_q;
endmodule

// File: rtl/txr_engine_chk.sv
module txr_engine_chk #(
  parameter int FBUF_BYTES = 2048,
  localparam int POS_W = $clog2(FBUF_BYTES) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pend_wr,
  input logic [31:0]      pend_reg,
  input logic             mem_req,
  input logic             mem_we,
  input logic [31:0]      mem_addr,
  input logic [31:0]      mem_wdata,
  input logic             mem_ready,
  input logic             frm_valid,
  input logic             frm_last,
  input logic [POS_W-1:0] frm_len,
  input logic             evt_desc_done,
  input logic             evt_ring_idle
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_wb_own_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ring_idle |=> !mem_req);

  p_done_on_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_desc_done |-> mem_req && mem_we && mem_ready);

  p_pend_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_desc_done && !pend_wr |=> pend_reg == 32'h0);

  p_frame_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> (frm_len != '0) && (frm_len <= POS_W'(FBUF_BYTES)));

  p_last_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_last |-> frm_valid);

  p_evt_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_desc_done && evt_ring_idle));
endmodule

bind txr_engine txr_engine_chk #(.FBUF_BYTES(FBUF_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_wr(pend_wr), .pend_reg(pend_reg),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ready(mem_ready), .frm_valid(frm_valid), .frm_last(frm_last), .frm_len(frm_len),
  .evt_desc_done(evt_desc_done), .evt_ring_idle(evt_ring_idle)
);

// File: tb/txr_engine_test.sv
module txr_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pend_wr = 1'b0, ring_wr = 1'b0, tx_enable = 1'b1;
  logic [31:0] pend_wdata = '0, ring_wdata = '0;
  logic [7:0] ring_size = '0;
  logic [31:0] pend_reg, ring_reg, mem_addr, mem_wdata, mem_rdata;
  logic mem_req, mem_we, mem_ready, frm_valid, frm_last, evt_desc_done, evt_ring_idle;
  logic [7:0] frm_data;
  logic [11:0] frm_len;

  always #2 clk = ~clk;

  txr_engine uut (
    .clk(clk), .rst_n(rst_n), .pend_wr(pend_wr), .pend_wdata(pend_wdata),
    .ring_wr(ring_wr), .ring_wdata(ring_wdata), .ring_size(ring_size), .tx_enable(tx_enable),
    .pend_reg(pend_reg), .ring_reg(ring_reg), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .frm_valid(frm_valid), .frm_data(frm_data), .frm_last(frm_last), .frm_len(frm_len),
    .evt_desc_done(evt_desc_done), .evt_ring_idle(evt_ring_idle)
  );

  // host memory model: 4 KiB, ready on alternate cycles
  logic [31:0] bmem [0:1023];
  logic gap_q = 1'b0;
  assign mem_ready = mem_req && gap_q;
  assign mem_rdata = bmem[mem_addr[11:2]];
  always @(posedge clk) begin
    gap_q <= ~gap_q;
    if (mem_req && mem_ready && mem_we) bmem[mem_addr[11:2]] <= mem_wdata;
  end

  int checks = 0, errors = 0;
  int n_desc = 0, n_idle = 0, n_req = 0, n_frames = 0, viol = 0;
  int last_len = 0;
  logic [7:0] cur[$];
  logic [7:0] got[$];
  logic [7:0] exp[$];
  logic arm = 1'b0;
  logic [31:0] first_addr = '0;
  logic prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;
  int cyc = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (evt_desc_done) n_desc++;
      if (evt_ring_idle) n_idle++;
      if (mem_req) n_req++;
      if (arm && mem_req) begin first_addr = mem_addr; arm = 1'b0; end
      if (prev_stall && !(mem_req && mem_addr == prev_addr)) viol++;
      prev_stall = mem_req && !mem_ready;
      prev_addr = mem_addr;
      if (frm_valid) begin
        cur.push_back(frm_data);
        if (frm_last) begin got = cur; cur.delete(); n_frames++; last_len = int'(frm_len); end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic put_byte(input int a, input logic [7:0] b);
    bmem[a >> 2][8*(a % 4) +: 8] = b;
  endtask

  function automatic logic [31:0] dword(input bit own, input bit sop, input bit eop, input bit cks,
                                        input int stuff, input int start, input int len);
    return {own, sop, eop, cks, 8'(stuff), 6'(start), 1'b0, 13'(len)};
  endfunction

  task automatic put_desc(input int idx, input logic [31:0] st, input int ptr);
    bmem[(32'h100 + 8*idx) >> 2] = st;
    bmem[(32'h104 + 8*idx) >> 2] = ptr;
  endtask

  function automatic logic [15:0] ref_csum(input logic [7:0] f[$], input int st, input int n);
    int unsigned s = 0;
    for (int i = st; i < n; i++) s += ((i - st) % 2 == 0) ? (int'(f[i]) << 8) : int'(f[i]);
    while (s >> 16) s = (s & 32'hffff) + (s >> 16);
    return ~s[15:0];
  endfunction

  task automatic go_and_wait();
    int i0 = n_idle;
    arm = 1'b1;
    @(negedge clk); pend_wr = 1'b1; pend_wdata = 32'h1;
    @(negedge clk); pend_wr = 1'b0; pend_wdata = '0;
    while (n_idle == i0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic cmp_frame(input string req, input int n);
    int bad = 0;
    chk(last_len == n, req, "frame length", last_len, n);
    chk(got.size() == n, req, "bytes streamed", got.size(), n);
    for (int i = 0; i < n && i < got.size(); i++) if (got[i] !== exp[i]) bad++;
    chk(bad == 0, req, "frame byte mismatches", bad, 0);
  endtask

  task automatic t_reset();
    chk(pend_reg == 0, "R9", "pending after reset", pend_reg, 0);
    chk(ring_reg == 0, "R2", "ring register after reset", ring_reg, 0);
    chk(!mem_req && !frm_valid && !evt_desc_done && !evt_ring_idle, "R3", "outputs quiet after reset",
        {mem_req, frm_valid, evt_desc_done, evt_ring_idle}, 0);
  endtask

  task automatic t_zero_pend();
    int r0 = n_req;
    @(negedge clk); pend_wr = 1'b1; pend_wdata = 32'h0;
    @(negedge clk); pend_wr = 1'b0;
    repeat (10) @(negedge clk);
    chk(n_req == r0, "R1", "requests after zero pending write", n_req - r0, 0);
  endtask

  task automatic t_single();
    logic [31:0] st = dword(1, 1, 1, 0, 0, 0, 10);
    @(negedge clk); ring_wr = 1'b1; ring_wdata = 32'h0000_0100;
    @(negedge clk); ring_wr = 1'b0;
    exp.delete();
    for (int i = 0; i < 10; i++) begin put_byte(32'h201 + i, 8'h10 + 8'(i)); exp.push_back(8'h10 + 8'(i)); end
    put_desc(0, st, 32'h201);
    // first request must come the cycle after the pending write
    arm = 1'b1;
    @(negedge clk); pend_wr = 1'b1; pend_wdata = 32'h7;
    @(negedge clk); pend_wr = 1'b0;
    chk(mem_req && mem_addr == 32'h100 && !mem_we, "R1", "first request one cycle after start", mem_addr, 32'h100);
    begin
      int i0 = n_idle;
      while (n_idle == i0) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    chk(first_addr == 32'h100, "R2", "first descriptor address", first_addr, 32'h100);
    cmp_frame("R5", 10);
    chk(bmem[32'h100 >> 2] == (st & 32'h7fff_ffff), "R4", "status written back", bmem[32'h100 >> 2], st & 32'h7fff_ffff);
    chk(ring_reg == 32'h0000_0101, "R4", "index advanced", ring_reg, 32'h101);
    chk(n_desc == 1 && n_idle == 1, "R3", "events (desc<<8|idle)", n_desc * 256 + n_idle, 257);
    chk(pend_reg == 0, "R9", "pending cleared", pend_reg, 0);
  endtask

  task automatic t_cksum();
    logic [15:0] c;
    exp.delete();
    for (int i = 0; i < 5; i++) begin put_byte(32'h300 + i, 8'hA0 + 8'(i)); exp.push_back(8'hA0 + 8'(i)); end
    for (int i = 0; i < 7; i++) begin put_byte(32'h341 + i, 8'hC3 + 8'(5*i)); exp.push_back(8'hC3 + 8'(5*i)); end
    c = ref_csum(exp, 3, 12);
    exp[0] = c[15:8]; exp[1] = c[7:0];
    put_desc(1, dword(1, 1, 0, 1, 0, 3, 5), 32'h300);
    put_desc(2, dword(1, 0, 1, 1, 0, 0, 7), 32'h341);
    go_and_wait();
    cmp_frame("R7", 12);
    chk(got.size() > 1 && {got[0], got[1]} == c, "R7", "stuffed checksum", got.size() > 1 ? {got[0], got[1]} : 0, c);
    chk(ring_reg[7:0] == 8'd3, "R4", "index after two descriptors", ring_reg[7:0], 3);
    chk(n_desc == 3, "R9", "descriptor events", n_desc, 3);
  endtask

  task automatic t_txoff();
    int f0 = n_frames;
    logic [31:0] st = dword(1, 1, 1, 0, 0, 0, 4);
    tx_enable = 1'b0;
    put_desc(3, st, 32'h380);
    go_and_wait();
    chk(n_frames == f0, "R8", "frames while disabled", n_frames - f0, 0);
    chk(bmem[32'h118 >> 2] == (st & 32'h7fff_ffff), "R8", "write-back while disabled", bmem[32'h118 >> 2], st & 32'h7fff_ffff);
    tx_enable = 1'b1;
  endtask

  task automatic t_trunc();
    exp.delete();
    for (int i = 0; i < 2048; i++) begin put_byte(32'h800 + i, 8'(i) ^ 8'h5A); exp.push_back(8'(i) ^ 8'h5A); end
    put_desc(4, dword(1, 1, 1, 0, 0, 0, 2050), 32'h800);
    go_and_wait();
    cmp_frame("R6", 2048);
    chk(ring_reg[7:0] == 8'd5, "R4", "index after truncated frame", ring_reg[7:0], 5);
  endtask

  task automatic t_wrap();
    exp.delete();
    for (int i = 0; i < 3; i++) begin put_byte(32'h3C0 + i, 8'hE0 + 8'(i)); exp.push_back(8'hE0 + 8'(i)); end
    put_desc(15, dword(1, 1, 1, 0, 0, 0, 3), 32'h3C0);
    @(negedge clk); ring_wr = 1'b1; ring_wdata = 32'h0000_010F;
    @(negedge clk); ring_wr = 1'b0;
    go_and_wait();
    cmp_frame("R5", 3);
    chk(ring_reg == 32'h0000_0100, "R4", "index wraps at (size+1)*16", ring_reg, 32'h100);
    chk(viol == 0, "R10", "requests changed while stalled", viol, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_zero_pend();
    t_single();
    t_cksum();
    t_txoff();
    t_trunc();
    t_wrap();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog (R1..R10 run incomplete): actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule